// File: doc/BRIEF.md
# Random Access Scan Flip-Flop Array

A grid of test flip-flops in which any single cell can be loaded or observed on its own, with no serial chain to shift. A serial address register is filled one bit per cycle from the scan input pin. Its upper field drives a one-hot row decoder and its lower field drives a one-hot column decoder. The crossing of the active row and the active column picks exactly one cell. Only the cells whose next required value differs from their current contents need a write, so applying a vector costs far fewer cycles than a full chain shift.

Four mode inputs choose what a cycle does. The choices are: shift one address bit in, write the scan input bit into the selected cell, copy the selected cell to the scan output, or capture every cell in parallel from the response bus of the logic under test. The cell contents are driven out in parallel on `state_o` as that logic's pseudo-primary inputs. The default grid is 4x4, with a 4-bit address split 2/2.

Top module: `ras_array`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the address register, every cell and `scan_out_o` are cleared to 0.
- R2: A cycle with only `shift_addr_i` set moves the address left by one bit and enters `scan_in_i` as the new least significant bit. For example, 0101 followed by a 1 gives 1011.
- R3: Address bits [3:2] select the row and bits [1:0] select the column. The selected cell is bit `row*4+col` of `state_o`, which equals the address value.
- R4: A cycle with only `write_i` set loads `scan_in_i` into the selected cell at the clock edge. All other cells keep their values.
- R5: A cycle with only `read_i` set makes `scan_out_o` show the selected cell's value from the next edge on. `scan_out_o` holds its last value in every other cycle.
- R6: A cycle with only `capture_i` set loads bit i of `resp_i` into cell i for every i, all in the same cycle.
- R7: A cycle with no mode input set changes neither the cells, the address nor `scan_out_o`.
- R8: A cycle with two or more mode inputs set is ignored. It has the same effect as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scan_in_i | input | 1 | Serial address bit or write data bit |
| shift_addr_i | input | 1 | Shift one bit into the address register |
| write_i | input | 1 | Write scan_in_i into the selected cell |
| read_i | input | 1 | Copy the selected cell to scan_out_o |
| capture_i | input | 1 | Parallel load of all cells from resp_i |
| resp_i | input | 16 | Responses of the logic under test |
| state_o | output | 16 | Current cell contents, bit i is cell i |
| scan_out_o | output | 1 | Registered value of the last read |

## Verification
The bench walks every address through shift-then-write-then-read. A swapped row/column split or a shift in the wrong direction therefore lands on the wrong bit of `state_o` and shows up at once. Writes are applied over captured, non-uniform patterns, so a decoder that selects more than one cell disturbs a neighbour. Cycles with two modes at once are issued with data that would change the state if acted on, so a design with an implicit priority alters a cell or the address. A reset issued mid-run with all cells at one shows any cell that does not clear asynchronously.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_SHIFT,
    MODE_WRITE,
    MODE_READ,
    MODE_CAPTURE
  } ras_mode_e;

  // Exactly one request is honoured; zero or several give an idle cycle.
  function automatic ras_mode_e decode_mode(input logic shift_i, input logic write_i,
                                            input logic read_i, input logic capture_i);
    ras_mode_e m;
    m = MODE_IDLE;
    if ($countones({shift_i, write_i, read_i, capture_i}) == 1) begin
      if (shift_i)      m = MODE_SHIFT;
      else if (write_i) m = MODE_WRITE;
      else if (read_i)  m = MODE_READ;
      else              m = MODE_CAPTURE;
    end
    return m;
  endfunction
endpackage

// File: rtl/ras_addr_reg.sv
module ras_addr_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (shift_i) addr_o <= {addr_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/ras_onehot_dec.sv
module ras_onehot_dec #(
  parameter int  IN_W  = 2,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_N-1:0] out_o
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign out_o[k] = (in_i == IN_W'(k));
  end
endmodule

// File: rtl/ras_cell_array.sv
module ras_cell_array #(
  parameter int  ROWS = 4,
  parameter int  COLS = 4,
  localparam int N    = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ROWS-1:0] row_sel_i,
  input  logic [COLS-1:0] col_sel_i,
  input  logic            wr_en_i,
  input  logic            cap_en_i,
  input  logic            wr_bit_i,
  input  logic [N-1:0]    resp_i,
  output logic [N-1:0]    q_o,
  output logic [N-1:0]    sel_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      assign sel_o[IDX] = row_sel_i[r] & col_sel_i[c];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       q_o[IDX] <= 1'b0;
        else if (cap_en_i)                 q_o[IDX] <= resp_i[IDX];
        else if (wr_en_i && sel_o[IDX])    q_o[IDX] <= wr_bit_i;
      end
    end
  end
endmodule

// File: rtl/ras_array.sv
module ras_array #(
  parameter int  ROW_BITS = 2,
  parameter int  COL_BITS = 2,
  localparam int ADDR_W   = ROW_BITS + COL_BITS,
  localparam int ROWS     = 1 << ROW_BITS,
  localparam int COLS     = 1 << COL_BITS,
  localparam int N_FF     = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scan_in_i,
  input  logic            shift_addr_i,
  input  logic            write_i,
  input  logic            read_i,
  input  logic            capture_i,
  input  logic [N_FF-1:0] resp_i,
  output logic [N_FF-1:0] state_o,
  output logic            scan_out_o
);
  import ras_pkg::*;

  ras_mode_e         mode;
  logic [ADDR_W-1:0] addr_q;
  logic [ROWS-1:0]   row_sel;
  logic [COLS-1:0]   col_sel;
  logic [N_FF-1:0]   sel;
  logic              rd_bit;

  assign mode = decode_mode(shift_addr_i, write_i, read_i, capture_i);

  ras_addr_reg #(.W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(mode == MODE_SHIFT),
    .bit_i  (scan_in_i),
    .addr_o (addr_q)
  );

  ras_onehot_dec #(.IN_W(ROW_BITS)) u_row_dec (
    .in_i (addr_q[ADDR_W-1:COL_BITS]),
    .out_o(row_sel)
  );

  ras_onehot_dec #(.IN_W(COL_BITS)) u_col_dec (
    .in_i (addr_q[COL_BITS-1:0]),
    .out_o(col_sel)
  );

  ras_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .row_sel_i(row_sel),
    .col_sel_i(col_sel),
    .wr_en_i  (mode == MODE_WRITE),
    .cap_en_i (mode == MODE_CAPTURE),
    .wr_bit_i (scan_in_i),
    .resp_i   (resp_i),
    .q_o      (state_o),
    .sel_o    (sel)
  );

  // AND-OR read mux driven by the one-hot cell select
  assign rd_bit = |(state_o & sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 scan_out_o <= 1'b0;
    else if (mode == MODE_READ)  scan_out_o <= rd_bit;
  end
endmodule

// File: rtl/ras_array_chk.sv
module ras_array_chk #(
  parameter int ADDR_W = 4,
  parameter int N_FF   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scan_in_i,
  input logic              shift_addr_i,
  input logic              write_i,
  input logic              read_i,
  input logic              capture_i,
  input logic [N_FF-1:0]   resp_i,
  input logic [N_FF-1:0]   state_o,
  input logic              scan_out_o,
  input logic [ADDR_W-1:0] addr_q,
  input logic [N_FF-1:0]   sel
);
  logic [3:0] req;
  logic       one_req;
  assign req     = {shift_addr_i, write_i, read_i, capture_i};
  assign one_req = ($countones(req) == 1);

  p_sel_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel) == 1 && sel[addr_q]);

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_req && shift_addr_i) |=> addr_q == {$past(addr_q[ADDR_W-2:0]), $past(scan_in_i)});

  p_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_req && write_i) |=> state_o[$past(addr_q)] == $past(scan_in_i)
      && $countones(state_o ^ $past(state_o)) <= 1);

  p_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_req && read_i) |=> scan_out_o == $past(state_o[addr_q]));

  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(one_req && read_i) |=> $stable(scan_out_o));

  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_req && capture_i) |=> state_o == $past(resp_i));

  p_idle_r7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !one_req |=> $stable(state_o) && $stable(addr_q));
endmodule

bind ras_array ras_array_chk #(.ADDR_W(ADDR_W), .N_FF(N_FF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_in_i   (scan_in_i),
  .shift_addr_i(shift_addr_i),
  .write_i     (write_i),
  .read_i      (read_i),
  .capture_i   (capture_i),
  .resp_i      (resp_i),
  .state_o     (state_o),
  .scan_out_o  (scan_out_o),
  .addr_q      (addr_q),
  .sel         (sel)
);

// File: tb/ras_array_tb_top.sv
module ras_array_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scan_in_i = 1'b0;
  logic        shift_addr_i = 1'b0;
  logic        write_i = 1'b0;
  logic        read_i = 1'b0;
  logic        capture_i = 1'b0;
  logic [15:0] resp_i = '0;
  logic [15:0] state_o;
  logic        scan_out_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  logic [15:0] ref_ff = '0;
  int          ref_addr = 0;
  logic        ref_out = 1'b0;

  always #10 clk_i = ~clk_i;

  ras_array dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_in_i(scan_in_i),
    .shift_addr_i(shift_addr_i), .write_i(write_i), .read_i(read_i),
    .capture_i(capture_i), .resp_i(resp_i), .state_o(state_o),
    .scan_out_o(scan_out_o)
  );

  task automatic compare(input string tag);
    checks++;
    if (state_o !== ref_ff) begin
      errors++;
      $display("FAIL %s state_o actual=%h expected=%h", tag, state_o, ref_ff);
    end
    checks++;
    if (scan_out_o !== ref_out) begin
      errors++;
      $display("FAIL %s scan_out_o actual=%b expected=%b", tag, scan_out_o, ref_out);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic r, input logic c,
                      input logic si, input logic [15:0] resp, input string tag);
    shift_addr_i = s; write_i = w; read_i = r; capture_i = c;
    scan_in_i = si; resp_i = resp;
    @(posedge clk_i);
    if (int'(s) + int'(w) + int'(r) + int'(c) == 1) begin
      if (s)      ref_addr = ((ref_addr << 1) | int'(si)) & 15;
      else if (w) ref_ff[ref_addr] = si;
      else if (r) ref_out = ref_ff[ref_addr];
      else        ref_ff = resp;
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic load_addr(input int a, input string tag);
    for (int b = 3; b >= 0; b--) step(1, 0, 0, 0, a[b], 16'h0, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk_i);
    rst_ni = 1'b0;
    ref_ff = '0; ref_addr = 0; ref_out = 1'b0;
    #5;
    compare(tag);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1 initial reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // address 0101, then one shift of 1 gives 1011
    load_addr(5, "R2 load 0101");
    step(0, 1, 0, 0, 1, 16'h0, "R4 write cell 5");
    step(1, 0, 0, 0, 1, 16'h0, "R2 0101 to 1011");
    step(0, 1, 0, 0, 1, 16'h0, "R4 write cell 11");
    step(0, 0, 1, 0, 0, 16'h0, "R5 read cell 11");
    step(1, 0, 0, 0, 0, 16'h0, "R2 1011 to 0110");
    step(0, 0, 1, 0, 0, 16'h0, "R5 read cell 6");
    step(0, 0, 0, 0, 1, 16'hFFFF, "R7 idle hold");
    step(0, 0, 0, 0, 0, 16'h1234, "R7 idle hold");

    step(0, 0, 0, 1, 0, 16'hA5C3, "R6 capture A5C3");
    step(0, 0, 1, 0, 0, 16'h0, "R5 read cell 6 after capture");
    step(0, 1, 0, 0, 0, 16'h0, "R4 clear cell 6");
    step(0, 0, 1, 0, 0, 16'h0, "R5 read cleared cell");

    step(1, 1, 0, 0, 1, 16'h0, "R8 shift+write ignored");
    step(0, 0, 1, 1, 1, 16'hFFFF, "R8 read+capture ignored");
    step(1, 1, 1, 1, 1, 16'h0F0F, "R8 all modes ignored");
    step(0, 0, 1, 0, 0, 16'h0, "R8 address unchanged");

    // walk every address: flip the cell, read it back
    step(0, 0, 0, 1, 0, 16'h6E19, "R6 capture 6E19");
    for (int a = 0; a < 16; a++) begin
      load_addr(a, "R3 address walk");
      step(0, 1, 0, 0, ~ref_ff[a], 16'h0, "R3 write walk");
      step(0, 0, 1, 0, 0, 16'h0, "R3 read walk");
    end

    step(0, 0, 0, 1, 0, 16'h3C96, "R6 capture 3C96");
    for (int a = 15; a >= 0; a--) begin
      load_addr(a, "R3 readback addr");
      step(0, 0, 1, 0, 0, 16'h0, "R5 readback");
    end

    step(0, 0, 0, 1, 0, 16'hFFFF, "R6 capture all ones");
    step(0, 0, 1, 0, 0, 16'h0, "R5 read one");
    do_reset("R1 mid-run reset");
    step(0, 0, 1, 0, 0, 16'h0, "R1 address cleared");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule